// File: doc/BRIEF.md
# Vector Configuration and Status Registers

This block keeps the configuration and status state of a vector unit for one hart. It holds the current element-interpretation word (element width, register-group multiplier, tail and mask policy, and an illegal-configuration flag), the active vector length, the resume index used after a trap, the fixed-point rounding mode and the sticky saturation flag. It also holds the two-bit context-status field that lives in the machine status word.

The set-length operation takes a requested configuration word and an application vector length (AVL) and grants `vl = min(AVL, VLMAX)`, where VLMAX = LMUL·VLEN/SEW. An unsupported request leaves only the illegal flag set and grants a length of zero. The configuration word and the length can be written only by that operation. The length can also be written from a fault-only-first load side input. Software reaches the registers through a CSR port that answers one cycle later. Trap logic loads the resume index, and the datapath raises saturation.

When the context-status field reads Off, vector work and vector CSR accesses raise a trap request and change nothing. When the field is not Off, any change to vector state moves it to Dirty.

Top module: `vcfg_csr_unit`

## Requirements
- R1: After reset the configuration word reads 0x8000_0000 (bit XLEN-1 set, all others zero). vl, vstart, vxrm and vxsat read 0, and the context field reads Off (00).
- R2: A set-length operation with a legal request stores its low 8 bits as the configuration word and grants vl = min(AVL, VLMAX). The layout is multiplier code in [2:0], width code in [5:3], tail policy in bit 6 and mask policy in bit 7. Multiplier codes are 000=1, 001=2, 010=4, 011=8, 111=1/2, 110=1/4, 101=1/8. Width codes are 000=8, 001=16, 010=32, 011=64.
- R3: A request is illegal if it has multiplier code 100, a width code above 011 or a width above ELEN, any nonzero bit in [XLEN-1:8], or a fractional multiplier with SEW > LMUL·ELEN. It sets the configuration word to only bit XLEN-1 and sets vl to 0.
- R4: CSR writes to vl (0xC20), the configuration word (0xC21) and vlenb (0xC22) are answered as illegal and leave vl and the configuration word unchanged.
- R5: Reading vlenb (0xC22) returns VLEN/8 and changes neither vl nor the configuration word.
- R6: vstart (0x008) is read/write through the CSR port on its low log2(VLEN) bits. A completed vector instruction or a set-length operation clears it, and a trap-logic write loads the faulting element index.
- R7: A fault-only-first write loads its value into vl and leaves the configuration word unchanged.
- R8: vxsat (0x009) is bit 0, vxrm (0x00A) is bits [1:0], and the combined register (0x00F) holds vxsat in bit 0 and vxrm in bits [2:1]. A write through either view is seen in both.
- R9: vxsat is sticky: a saturation pulse sets it, and only a CSR write clears it.
- R10: Every CSR request gets a response one cycle later. An address outside the seven registers is answered as illegal with read data 0.
- R11: The context field is written through its own port with encoding Off=00, Initial=01, Clean=10, Dirty=11. While it is Off, a set-length operation, a completed vector instruction or an access to a vector CSR raises the trap request one cycle later, the CSR access is answered as illegal, and no register changes.
- R12: While the field is not Off, any change of vector state sets it to Dirty (11): a set-length operation, instruction completion, a successful CSR write, a trap index write, a fault-only-first write or saturation. CSR reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | CSR access request |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| rsp_valid | output | 1 | CSR response valid, one cycle after the request |
| rsp_illegal | output | 1 | CSR access was rejected |
| rsp_rdata | output | XLEN | CSR read data (value before any write) |
| setvl_req | input | 1 | Set-length operation |
| setvl_vtype | input | XLEN | Requested configuration word |
| setvl_avl | input | XLEN | Application vector length |
| vinstr_done | input | 1 | A vector instruction completed |
| trap_vstart_we | input | 1 | Trap logic writes the resume index |
| trap_vstart_idx | input | VS_W | Faulting element index |
| ffl_vl_we | input | 1 | Fault-only-first load trims vl |
| ffl_vl | input | VL_W | New vl from the fault-only-first load |
| sat_set | input | 1 | Datapath saturated |
| ms_vs_we | input | 1 | Write of the context field |
| ms_vs_wdata | input | 2 | New context field value |
| vtype_o | output | XLEN | Current configuration word |
| vl_o | output | VL_W | Current vector length |
| vstart_o | output | VS_W | Current resume index |
| vxrm_o | output | 2 | Rounding mode |
| vxsat_o | output | 1 | Saturation flag |
| vs_o | output | 2 | Context status field |
| vtrap_o | output | 1 | Trap request pulse |

## Verification
The assertions assume that at most one of the operation inputs (CSR request, set-length, instruction completion, trap index write, fault-only-first write, saturation, context write) is active in any cycle. They also assume that a fault-only-first value never exceeds the current vl, so the length-bound and stability properties hold. The stimulus issues every operation from its own task, one per call, with the strobe held for one cycle and dropped before the next call starts. Fault-only-first values are taken only below the granted length.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  localparam logic [11:0] CSR_VSTART = 12'h008;
  localparam logic [11:0] CSR_VXSAT  = 12'h009;
  localparam logic [11:0] CSR_VXRM   = 12'h00A;
  localparam logic [11:0] CSR_VCSR   = 12'h00F;
  localparam logic [11:0] CSR_VL     = 12'hC20;
  localparam logic [11:0] CSR_VTYPE  = 12'hC21;
  localparam logic [11:0] CSR_VLENB  = 12'hC22;

  typedef enum logic [1:0] {
    CTX_OFF   = 2'b00,
    CTX_INIT  = 2'b01,
    CTX_CLEAN = 2'b10,
    CTX_DIRTY = 2'b11
  } ctx_e;

  // Compact stored form of the configuration word.
  typedef struct packed {
    logic       ill;
    logic       mask_agn;
    logic       tail_agn;
    logic [2:0] sew_code;
    logic [2:0] lmul_code;
  } vcfg_t;

endpackage

// File: rtl/vcfg_grant.sv
// Combinational legality check and granted-length computation.
module vcfg_grant
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int VL_W = $clog2(VLEN) + 1
) (
  input  logic [XLEN-1:0] req_vtype,
  input  logic [XLEN-1:0] req_avl,
  output vcfg_t           cfg_o,
  output logic [VL_W-1:0] vl_o
);

  localparam int SEW_MAX = $clog2(ELEN) - 3;
  localparam int N_SHIFT = 16;

  // VLEN >> shift for every shift the encoding can produce.
  logic [VL_W-1:0] vlmax_tab [N_SHIFT];

  generate
    for (genvar s = 0; s < N_SHIFT; s++) begin : g_tab
      assign vlmax_tab[s] = VL_W'(VLEN >> s);
    end
  endgenerate

  logic [2:0]      lmul;
  logic [2:0]      sew;
  logic            frac;
  logic [3:0]      frac_steps;
  logic [3:0]      grow;
  logic [3:0]      shift;
  logic            bad;
  logic [VL_W-1:0] vlmax;

  always_comb begin
    lmul       = req_vtype[2:0];
    sew        = req_vtype[5:3];
    frac       = lmul[2];
    frac_steps = frac ? (4'd8 - {1'b0, lmul}) : 4'd0;
    grow       = frac ? 4'd0 : {1'b0, lmul};
    shift      = 4'd3 + {1'b0, sew} + frac_steps - grow;
    vlmax      = vlmax_tab[shift];
    bad        = (lmul == 3'b100)
              || ({1'b0, sew} > 4'(SEW_MAX))
              || (|req_vtype[XLEN-1:8])
              || (frac && (({1'b0, sew} + frac_steps) > 4'(SEW_MAX)));
    if (bad) begin
      cfg_o = '{ill: 1'b1, default: '0};
      vl_o  = '0;
    end else begin
      cfg_o = vcfg_t'({1'b0, req_vtype[7:0]});
      vl_o  = (req_avl < XLEN'(vlmax)) ? req_avl[VL_W-1:0] : vlmax;
    end
  end

endmodule

// File: rtl/vcfg_ctx.sv
// Context-status field: Off / Initial / Clean / Dirty.
module vcfg_ctx
  import vcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_val,
  input  logic       dirty_ev,
  output ctx_e       state_o
);

  always_ff @(posedge clk) begin
    if (rst)           state_o <= CTX_OFF;
    else if (wr_en)    state_o <= ctx_e'(wr_val);
    else if (dirty_ev) state_o <= CTX_DIRTY;
  end

endmodule

// File: rtl/vcfg_fixpt.sv
// Fixed-point rounding mode and sticky saturation flag.
module vcfg_fixpt (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_vxrm,
  input  logic       wr_vxsat,
  input  logic       wr_vcsr,
  input  logic [2:0] wdata,
  input  logic       sat_set,
  output logic [1:0] vxrm_o,
  output logic       vxsat_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vxrm_o  <= 2'b00;
      vxsat_o <= 1'b0;
    end else if (wr_vcsr) begin
      vxrm_o  <= wdata[2:1];
      vxsat_o <= wdata[0];
    end else begin
      if (wr_vxrm) vxrm_o <= wdata[1:0];
      if (wr_vxsat)     vxsat_o <= wdata[0];
      else if (sat_set) vxsat_o <= 1'b1;
    end
  end

endmodule

// File: rtl/vcfg_csr_unit.sv
module vcfg_csr_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int VL_W = $clog2(VLEN) + 1,
  parameter int VS_W = $clog2(VLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic            rsp_valid,
  output logic            rsp_illegal,
  output logic [XLEN-1:0] rsp_rdata,
  input  logic            setvl_req,
  input  logic [XLEN-1:0] setvl_vtype,
  input  logic [XLEN-1:0] setvl_avl,
  input  logic            vinstr_done,
  input  logic            trap_vstart_we,
  input  logic [VS_W-1:0] trap_vstart_idx,
  input  logic            ffl_vl_we,
  input  logic [VL_W-1:0] ffl_vl,
  input  logic            sat_set,
  input  logic            ms_vs_we,
  input  logic [1:0]      ms_vs_wdata,
  output logic [XLEN-1:0] vtype_o,
  output logic [VL_W-1:0] vl_o,
  output logic [VS_W-1:0] vstart_o,
  output logic [1:0]      vxrm_o,
  output logic            vxsat_o,
  output logic [1:0]      vs_o,
  output logic            vtrap_o
);

  localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);

  vcfg_t           vtype_q;
  logic [VL_W-1:0] vl_q;
  logic [VS_W-1:0] vstart_q;
  vcfg_t           grant_cfg;
  logic [VL_W-1:0] grant_vl;
  ctx_e            ctx_q;
  logic            ctx_off;
  logic [1:0]      vxrm_q;
  logic            vxsat_q;

  logic            known;
  logic            is_ro;
  logic            acc_ok;
  logic            wr_ok;
  logic [XLEN-1:0] rd_mux;
  logic [XLEN-1:0] vtype_full;
  logic            dirty_ev;
  logic            unused_wdata;

  assign unused_wdata = ^csr_wdata[XLEN-1:VS_W];
  assign ctx_off      = (ctx_q == CTX_OFF);
  assign vtype_full   = {vtype_q.ill, {(XLEN-9){1'b0}}, vtype_q.mask_agn,
                         vtype_q.tail_agn, vtype_q.sew_code, vtype_q.lmul_code};

  vcfg_grant #(
    .XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)
  ) u_grant (
    .req_vtype(setvl_vtype),
    .req_avl  (setvl_avl),
    .cfg_o    (grant_cfg),
    .vl_o     (grant_vl)
  );

  // CSR decode and read mux
  always_comb begin
    known  = 1'b1;
    is_ro  = 1'b0;
    rd_mux = '0;
    case (csr_addr)
      CSR_VSTART: rd_mux = XLEN'(vstart_q);
      CSR_VXSAT:  rd_mux = XLEN'(vxsat_q);
      CSR_VXRM:   rd_mux = XLEN'(vxrm_q);
      CSR_VCSR:   rd_mux = XLEN'({vxrm_q, vxsat_q});
      CSR_VL:     begin rd_mux = XLEN'(vl_q); is_ro = 1'b1; end
      CSR_VTYPE:  begin rd_mux = vtype_full;  is_ro = 1'b1; end
      CSR_VLENB:  begin rd_mux = VLENB_VAL;   is_ro = 1'b1; end
      default:    known = 1'b0;
    endcase
    acc_ok = csr_req && known && !ctx_off && !(csr_we && is_ro);
    wr_ok  = acc_ok && csr_we;
  end

  assign dirty_ev = !ctx_off && (setvl_req || vinstr_done || trap_vstart_we ||
                                 ffl_vl_we || sat_set || wr_ok);

  // Configuration, length and resume index
  always_ff @(posedge clk) begin
    if (rst) begin
      vtype_q  <= '{ill: 1'b1, default: '0};
      vl_q     <= '0;
      vstart_q <= '0;
    end else if (!ctx_off) begin
      if (trap_vstart_we) begin
        vstart_q <= trap_vstart_idx;
      end else if (vinstr_done) begin
        vstart_q <= '0;
      end else if (setvl_req) begin
        vtype_q  <= grant_cfg;
        vl_q     <= grant_vl;
        vstart_q <= '0;
      end else if (ffl_vl_we) begin
        vl_q <= ffl_vl;
      end else if (wr_ok && csr_addr == CSR_VSTART) begin
        vstart_q <= csr_wdata[VS_W-1:0];
      end
    end
  end

  vcfg_fixpt u_fixpt (
    .clk     (clk),
    .rst     (rst),
    .wr_vxrm (wr_ok && csr_addr == CSR_VXRM),
    .wr_vxsat(wr_ok && csr_addr == CSR_VXSAT),
    .wr_vcsr (wr_ok && csr_addr == CSR_VCSR),
    .wdata   (csr_wdata[2:0]),
    .sat_set (sat_set && !ctx_off),
    .vxrm_o  (vxrm_q),
    .vxsat_o (vxsat_q)
  );

  vcfg_ctx u_ctx (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ms_vs_we),
    .wr_val  (ms_vs_wdata),
    .dirty_ev(dirty_ev),
    .state_o (ctx_q)
  );

  // Registered CSR response and trap request
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
      vtrap_o     <= 1'b0;
    end else begin
      rsp_valid   <= csr_req;
      rsp_illegal <= csr_req && !acc_ok;
      rsp_rdata   <= acc_ok ? rd_mux : '0;
      vtrap_o     <= ctx_off && (setvl_req || vinstr_done || (csr_req && known));
    end
  end

  assign vtype_o  = vtype_full;
  assign vl_o     = vl_q;
  assign vstart_o = vstart_q;
  assign vxrm_o   = vxrm_q;
  assign vxsat_o  = vxsat_q;
  assign vs_o     = ctx_q;

endmodule

// File: rtl/vcfg_csr_unit_chk.sv
module vcfg_csr_unit_chk #(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int VL_W = $clog2(VLEN) + 1,
  parameter int VS_W = $clog2(VLEN)
) (
  input logic            clk,
  input logic            rst,
  input logic            csr_req,
  input logic            csr_we,
  input logic [11:0]     csr_addr,
  input logic            setvl_req,
  input logic            vinstr_done,
  input logic            trap_vstart_we,
  input logic            ms_vs_we,
  input logic            rsp_valid,
  input logic            rsp_illegal,
  input logic [XLEN-1:0] rsp_rdata,
  input logic [XLEN-1:0] vtype_o,
  input logic [VL_W-1:0] vl_o,
  input logic [VS_W-1:0] vstart_o,
  input logic [1:0]      vxrm_o,
  input logic            vxsat_o,
  input logic [1:0]      vs_o,
  input logic            vtrap_o
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vtype_o == {1'b1, {(XLEN-1){1'b0}}} && vl_o == '0 && vs_o == 2'b00));

  assert_vl_bound_R2: assert property (@(posedge clk) disable iff (rst)
    vl_o <= VL_W'(VLEN));

  assert_ill_clears_rest_R3: assert property (@(posedge clk) disable iff (rst)
    vtype_o[XLEN-1] |-> (vtype_o[XLEN-2:0] == '0));

  assert_ro_write_rejected_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_we && (csr_addr == 12'hC20 || csr_addr == 12'hC21 || csr_addr == 12'hC22))
    |=> (rsp_illegal && $stable(vtype_o) && $stable(vl_o)));

  assert_vlenb_value_R5: assert property (@(posedge clk) disable iff (rst)
    (csr_req && !csr_we && csr_addr == 12'hC22 && vs_o != 2'b00)
    |=> (rsp_rdata == XLEN'(VLEN / 8)));

  assert_done_clears_vstart_R6: assert property (@(posedge clk) disable iff (rst)
    (vinstr_done && !trap_vstart_we && vs_o != 2'b00) |=> (vstart_o == '0));

  assert_vcsr_mirror_R8: assert property (@(posedge clk) disable iff (rst)
    (csr_req && !csr_we && csr_addr == 12'h00F && vs_o != 2'b00)
    |=> (rsp_rdata == {{(XLEN-3){1'b0}}, $past(vxrm_o), $past(vxsat_o)}));

  assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (vxsat_o && !(csr_req && csr_we)) |=> vxsat_o);

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    csr_req |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    !csr_req |=> !rsp_valid);

  assert_off_traps_R11: assert property (@(posedge clk) disable iff (rst)
    (vs_o == 2'b00 && setvl_req) |=> (vtrap_o && $stable(vtype_o) && $stable(vl_o)));

  assert_change_dirties_R12: assert property (@(posedge clk) disable iff (rst)
    (vs_o != 2'b00 && !ms_vs_we && (setvl_req || vinstr_done)) |=> (vs_o == 2'b11));

endmodule

bind vcfg_csr_unit vcfg_csr_unit_chk #(
  .XLEN(XLEN), .VLEN(VLEN), .VL_W(VL_W), .VS_W(VS_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .csr_req       (csr_req),
  .csr_we        (csr_we),
  .csr_addr      (csr_addr),
  .setvl_req     (setvl_req),
  .vinstr_done   (vinstr_done),
  .trap_vstart_we(trap_vstart_we),
  .ms_vs_we      (ms_vs_we),
  .rsp_valid     (rsp_valid),
  .rsp_illegal   (rsp_illegal),
  .rsp_rdata     (rsp_rdata),
  .vtype_o       (vtype_o),
  .vl_o          (vl_o),
  .vstart_o      (vstart_o),
  .vxrm_o        (vxrm_o),
  .vxsat_o       (vxsat_o),
  .vs_o          (vs_o),
  .vtrap_o       (vtrap_o)
);

// File: tb/vcfg_csr_unit_test.sv
`timescale 1ns/1ps
module vcfg_csr_unit_test;

  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VL_W = $clog2(VLEN) + 1;
  localparam int VS_W = $clog2(VLEN);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            csr_req = 1'b0, csr_we = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic            rsp_valid, rsp_illegal;
  logic [XLEN-1:0] rsp_rdata;
  logic            setvl_req = 1'b0;
  logic [XLEN-1:0] setvl_vtype = '0, setvl_avl = '0;
  logic            vinstr_done = 1'b0, trap_vstart_we = 1'b0;
  logic [VS_W-1:0] trap_vstart_idx = '0;
  logic            ffl_vl_we = 1'b0;
  logic [VL_W-1:0] ffl_vl = '0;
  logic            sat_set = 1'b0, ms_vs_we = 1'b0;
  logic [1:0]      ms_vs_wdata = '0;
  logic [XLEN-1:0] vtype_o;
  logic [VL_W-1:0] vl_o;
  logic [VS_W-1:0] vstart_o;
  logic [1:0]      vxrm_o, vs_o;
  logic            vxsat_o, vtrap_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  vcfg_csr_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) uut (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
    .rsp_rdata(rsp_rdata), .setvl_req(setvl_req), .setvl_vtype(setvl_vtype),
    .setvl_avl(setvl_avl), .vinstr_done(vinstr_done), .trap_vstart_we(trap_vstart_we),
    .trap_vstart_idx(trap_vstart_idx), .ffl_vl_we(ffl_vl_we), .ffl_vl(ffl_vl),
    .sat_set(sat_set), .ms_vs_we(ms_vs_we), .ms_vs_wdata(ms_vs_wdata),
    .vtype_o(vtype_o), .vl_o(vl_o), .vstart_o(vstart_o), .vxrm_o(vxrm_o),
    .vxsat_o(vxsat_o), .vs_o(vs_o), .vtrap_o(vtrap_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model of legality and VLMAX (fractions, not shifts)
  function automatic bit exp_ill(input logic [31:0] vt);
    int lm = int'(vt[2:0]);
    int sw = int'(vt[5:3]);
    int sew = 8 << sw;
    if (vt[31:8] != 0) return 1;
    if (lm == 4) return 1;
    if (sw > 3 || sew > ELEN) return 1;
    if (lm >= 5 && sew * (1 << (8 - lm)) > ELEN) return 1;
    return 0;
  endfunction

  function automatic int exp_vlmax(input logic [31:0] vt);
    int lm = int'(vt[2:0]);
    int sew = 8 << int'(vt[5:3]);
    int num = (lm < 4) ? (1 << lm) : 1;
    int den = (lm >= 5) ? (1 << (8 - lm)) : 1;
    return (VLEN * num) / (sew * den);
  endfunction

  function automatic logic [31:0] exp_vtype(input logic [31:0] vt);
    return exp_ill(vt) ? 32'h8000_0000 : {24'd0, vt[7:0]};
  endfunction

  function automatic logic [31:0] exp_vl(input logic [31:0] vt, input logic [31:0] avl);
    longint vm;
    if (exp_ill(vt)) return 0;
    vm = longint'(exp_vlmax(vt));
    return (longint'(avl) < vm) ? avl : 32'(vm);
  endfunction

  task automatic do_setvl(input logic [31:0] vt, input logic [31:0] avl);
    @(negedge clk);
    setvl_req = 1'b1; setvl_vtype = vt; setvl_avl = avl;
    @(negedge clk);
    setvl_req = 1'b0;
  endtask

  task automatic csr_op(input bit we, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output bit ill, output bit trap);
    @(negedge clk);
    csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; ill = rsp_illegal; trap = vtrap_o;
    chk("R10 response valid", 32'(rsp_valid), 1);
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic ms_write(input logic [1:0] v);
    @(negedge clk); ms_vs_we = 1'b1; ms_vs_wdata = v;
    @(negedge clk); ms_vs_we = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); vinstr_done = 1'b1;
    @(negedge clk); vinstr_done = 1'b0;
  endtask

  task automatic pulse_trap(input logic [VS_W-1:0] idx);
    @(negedge clk); trap_vstart_we = 1'b1; trap_vstart_idx = idx;
    @(negedge clk); trap_vstart_we = 1'b0;
  endtask

  task automatic pulse_ffl(input logic [VL_W-1:0] v);
    @(negedge clk); ffl_vl_we = 1'b1; ffl_vl = v;
    @(negedge clk); ffl_vl_we = 1'b0;
  endtask

  task automatic pulse_sat();
    @(negedge clk); sat_set = 1'b1;
    @(negedge clk); sat_set = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, vt, avl, saved_vt, saved_vl;
    bit ill, trap;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 vtype reset", vtype_o, 32'h8000_0000);
    chk("R1 vl reset", 32'(vl_o), 0);
    chk("R1 vstart reset", 32'(vstart_o), 0);
    chk("R1 vxrm reset", 32'(vxrm_o), 0);
    chk("R1 vxsat reset", 32'(vxsat_o), 0);
    chk("R1 context reset Off", 32'(vs_o), 0);

    // Off: everything traps and nothing changes (R11)
    do_setvl(32'h0000_0010, 32'd5);
    chk("R11 setvl trap when Off", 32'(vtrap_o), 1);
    chk("R11 vl unchanged when Off", 32'(vl_o), 0);
    chk("R11 vtype unchanged when Off", vtype_o, 32'h8000_0000);
    pulse_done();
    chk("R11 instr trap when Off", 32'(vtrap_o), 1);
    csr_op(1'b1, 12'h00A, 32'd2, rd, ill, trap);
    chk("R11 csr illegal when Off", 32'(ill), 1);
    chk("R11 csr trap when Off", 32'(trap), 1);
    chk("R11 vxrm unchanged when Off", 32'(vxrm_o), 0);
    chk("R11 context still Off", 32'(vs_o), 0);

    ms_write(2'b01);
    chk("R11 context written Initial", 32'(vs_o), 1);
    csr_op(1'b0, 12'hC22, 32'd0, rd, ill, trap);
    chk("R5 vlenb value", rd, VLEN / 8);
    chk("R5 vlenb legal", 32'(ill), 0);
    chk("R5 vtype untouched by vlenb", vtype_o, 32'h8000_0000);
    chk("R5 vl untouched by vlenb", 32'(vl_o), 0);
    chk("R12 read keeps Initial", 32'(vs_o), 1);

    // Full sweep of width/multiplier codes (R2, R3)
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] avls [5];
        vt = {24'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'(s), 3'(m)};
        avls[0] = 32'd0;
        avls[1] = 32'(exp_vlmax(vt));
        avls[2] = 32'(exp_vlmax(vt) + 1);
        avls[3] = 32'hFFFF_FFFF;
        avls[4] = 32'($urandom_range(0, 300));
        for (int k = 0; k < 5; k++) begin
          do_setvl(vt, avls[k]);
          chk(exp_ill(vt) ? "R3 vtype illegal sweep" : "R2 vtype sweep", vtype_o, exp_vtype(vt));
          chk(exp_ill(vt) ? "R3 vl zero sweep" : "R2 vl sweep", 32'(vl_o), exp_vl(vt, avls[k]));
        end
      end
    end
    chk("R12 setvl dirties", 32'(vs_o), 3);

    // Reserved bits (R3)
    do_setvl(32'h0000_0108, 32'd4);
    chk("R3 reserved bit sets ill", vtype_o, 32'h8000_0000);
    chk("R3 reserved bit vl zero", 32'(vl_o), 0);
    do_setvl(32'h8000_0008, 32'd4);
    chk("R3 top bit request ill", vtype_o, 32'h8000_0000);

    // Read-only CSRs (R4)
    do_setvl(32'h0000_00D1, 32'd9);  // sew32 lmul2 -> VLMAX 8
    saved_vt = vtype_o; saved_vl = 32'(vl_o);
    chk("R2 vl clipped to VLMAX", saved_vl, 8);
    csr_op(1'b1, 12'hC20, 32'd3, rd, ill, trap);
    chk("R4 vl write illegal", 32'(ill), 1);
    csr_op(1'b1, 12'hC21, 32'd0, rd, ill, trap);
    chk("R4 vtype write illegal", 32'(ill), 1);
    csr_op(1'b1, 12'hC22, 32'd0, rd, ill, trap);
    chk("R4 vlenb write illegal", 32'(ill), 1);
    chk("R4 vtype unchanged", vtype_o, saved_vt);
    chk("R4 vl unchanged", 32'(vl_o), saved_vl);
    csr_op(1'b0, 12'hC21, 32'd0, rd, ill, trap);
    chk("R2 vtype csr read", rd, 32'h0000_00D1);
    csr_op(1'b0, 12'hC20, 32'd0, rd, ill, trap);
    chk("R2 vl csr read", rd, 8);

    // vstart (R6)
    csr_op(1'b1, 12'h008, 32'h0000_01FF, rd, ill, trap);
    chk("R6 vstart write legal", 32'(ill), 0);
    chk("R6 vstart low bits", 32'(vstart_o), 32'h7F);
    pulse_done();
    chk("R6 completion clears vstart", 32'(vstart_o), 0);
    pulse_trap(7'd5);
    chk("R6 trap loads index", 32'(vstart_o), 5);
    csr_op(1'b0, 12'h008, 32'd0, rd, ill, trap);
    chk("R6 vstart csr read", rd, 5);
    do_setvl(32'h0000_0010, 32'd3);
    chk("R6 setvl clears vstart", 32'(vstart_o), 0);

    // Fault-only-first (R7)
    saved_vt = vtype_o;
    pulse_ffl(8'd2);
    chk("R7 ffl loads vl", 32'(vl_o), 2);
    chk("R7 ffl keeps vtype", vtype_o, saved_vt);

    // Fixed-point views (R8)
    csr_op(1'b1, 12'h00A, 32'd2, rd, ill, trap);
    csr_op(1'b0, 12'h00F, 32'd0, rd, ill, trap);
    chk("R8 vcsr shows vxrm", rd, 32'b100);
    csr_op(1'b1, 12'h009, 32'd1, rd, ill, trap);
    csr_op(1'b0, 12'h00F, 32'd0, rd, ill, trap);
    chk("R8 vcsr shows both", rd, 32'b101);
    csr_op(1'b1, 12'h00F, 32'b011, rd, ill, trap);
    csr_op(1'b0, 12'h00A, 32'd0, rd, ill, trap);
    chk("R8 vxrm from vcsr", rd, 1);
    csr_op(1'b0, 12'h009, 32'd0, rd, ill, trap);
    chk("R8 vxsat from vcsr", rd, 1);

    // Sticky saturation (R9)
    csr_op(1'b1, 12'h009, 32'd0, rd, ill, trap);
    chk("R9 csr clears vxsat", 32'(vxsat_o), 0);
    pulse_sat();
    chk("R9 sat sets vxsat", 32'(vxsat_o), 1);
    repeat (4) @(negedge clk);
    do_setvl(32'h0000_0000, 32'd1);
    pulse_done();
    chk("R9 vxsat stays set", 32'(vxsat_o), 1);
    csr_op(1'b1, 12'h00F, 32'b000, rd, ill, trap);
    chk("R9 vcsr write clears", 32'(vxsat_o), 0);

    // Unknown address (R10)
    csr_op(1'b0, 12'h123, 32'd0, rd, ill, trap);
    chk("R10 unknown illegal", 32'(ill), 1);
    chk("R10 unknown rdata zero", rd, 0);

    // Dirty tracking (R12)
    ms_write(2'b10);
    csr_op(1'b0, 12'h00A, 32'd0, rd, ill, trap);
    chk("R12 read keeps Clean", 32'(vs_o), 2);
    csr_op(1'b1, 12'h00A, 32'd3, rd, ill, trap);
    chk("R12 csr write dirties", 32'(vs_o), 3);
    ms_write(2'b10);
    pulse_sat();
    chk("R12 saturation dirties", 32'(vs_o), 3);
    ms_write(2'b01);
    pulse_ffl(8'd1);
    chk("R12 ffl dirties", 32'(vs_o), 3);
    ms_write(2'b10);
    pulse_trap(7'd3);
    chk("R12 trap index dirties", 32'(vs_o), 3);

    // Constrained random configurations (R2, R3)
    for (int i = 0; i < 300; i++) begin
      vt  = ($urandom_range(0, 9) == 0) ? $urandom() : {24'd0, 8'($urandom())};
      avl = ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 140));
      do_setvl(vt, avl);
      chk(exp_ill(vt) ? "R3 vtype random" : "R2 vtype random", vtype_o, exp_vtype(vt));
      chk(exp_ill(vt) ? "R3 vl random" : "R2 vl random", 32'(vl_o), exp_vl(vt, avl));
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule